// File: doc/BRIEF.md
# Serial-Shift March Self-Test for an Embedded RAM

This block wraps the port of a WORDS-by-BITS embedded RAM and can run a march test on it. The test needs only one data bit. Each step reads a word, shifts it up one place, and writes it back. A single generated bit enters at the least significant end. The bit that falls out of the most significant end is compared with the value that entered BITS passes earlier. Repeating this BITS times over every address pushes a full word of the generated value through every cell of every word.

When the self-test enable input is low, the mission address, write data and write enable pass straight to the RAM port. The read data returns on the mission read output, and all test state is held cleared. When the enable is high, a pulse of the start input launches three groups of BITS ascending passes each. The first group shifts in zeros, the second shifts in ones, and the third shifts in zeros again. The completion flag then rises and stays up until start is released. A sticky mismatch flag and the last bit shifted out are visible at the ports.

Top module: `serial_ram_bist`

## Requirements
- R1: While `bist_on` is low, `ram_addr`, `ram_wdata` and `ram_we` equal `mis_addr`, `mis_wdata` and `mis_we` in the same cycle. `mis_rdata` always equals `ram_rdata`.
- R2: While `bist_on` is low, `done` and `fail` read 0 one cycle later, and `go` starts nothing.
- R3: During a test, every address gets a read cycle with `ram_we`=0 followed by a write cycle with `ram_we`=1 to the same address. Addresses ascend from 0 to WORDS-1 within each pass.
- R4: On each test write, `ram_wdata[BITS-1:1]` equals `ram_rdata[BITS-2:0]` of the word just read. `ram_wdata[0]` is the serial bit.
- R5: The serial bit is 0 for the first BITS*WORDS writes, 1 for the next BITS*WORDS writes and 0 for the last BITS*WORDS writes. That gives 3*BITS*WORDS writes in total.
- R6: In the second group the msb read is expected to be 0, and in the third group it is expected to be 1. The msb is not checked in the first group. `fail` goes to 1 on the first mismatch and holds until the next start, a reset, or `bist_on` going low.
- R7: `done` rises 6*BITS*WORDS+1 rising edges after `go` is first sampled high. It stays high while `go` stays high and falls one cycle after `go` goes low. `fail` keeps its value across that drop.
- R8: `sout` shows the msb of the word read in the most recent test write cycle.
- R9: A synchronous active-high `rst` clears `done`, `fail` and `sout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_on | input | 1 | Self-test enable; when low, the RAM port follows the mission inputs |
| go | input | 1 | Start request; hold it high until done |
| done | output | 1 | Test complete |
| fail | output | 1 | Sticky msb mismatch |
| sout | output | 1 | Last msb shifted out of a word |
| mis_addr | input | AW | Mission address |
| mis_wdata | input | BITS | Mission write data |
| mis_we | input | 1 | Mission write enable |
| mis_rdata | output | BITS | Mission read data |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | BITS | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | BITS | RAM read data, one cycle after the address |

## Verification
The bench models a RAM that reads first and can hold one cell stuck at a chosen value. The fault-free run starts from contents whose msbs are set. A clean `fail` therefore shows that the first group goes unchecked and that the shift chain flushes those contents. A bit stuck at 1 at the lsb or in the middle of a word shows up in the group that expects zeros. A bit stuck at 0 at the msb or in the middle shows up only in the group that expects ones. Every write in each run is compared with the shifted read word and with the expected address and serial bit.

// File: rtl/sbist_pkg.sv
package sbist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } sbist_state_t;

  // group index: 0 shifts zeros, 1 shifts ones, 2 shifts zeros
  localparam logic [1:0] GRP_LAST = 2'd2;
endpackage

// File: rtl/sbist_seq.sv
module sbist_seq #(
  parameter int WORDS = 8,
  parameter int BITS  = 4,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int PW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [1:0]    grp,
  output logic          last
);
  localparam logic [AW-1:0] ADDR_END = AW'(WORDS - 1);
  localparam logic [PW-1:0] PASS_END = PW'(BITS - 1);

  logic [PW-1:0] pass_q;
  logic          addr_wrap, pass_wrap;

  assign addr_wrap = (addr == ADDR_END);
  assign pass_wrap = (pass_q == PASS_END);
  assign last      = addr_wrap && pass_wrap && (grp == sbist_pkg::GRP_LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      addr   <= '0;
      pass_q <= '0;
      grp    <= '0;
    end else if (step) begin
      if (addr_wrap) begin
        addr <= '0;
        if (pass_wrap) begin
          pass_q <= '0;
          grp    <= grp + 2'd1;
        end else begin
          pass_q <= pass_q + 1'b1;
        end
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbist_ctrl.sv
module sbist_ctrl
  import sbist_pkg::*;
(
  input  logic         clk,
  input  logic         clr,
  input  logic         go,
  input  logic         seq_last,
  output sbist_state_t state,
  output logic         start
);
  sbist_state_t nxt;

  assign start = (state == ST_IDLE) && go;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (go) nxt = ST_READ;
      ST_READ:  nxt = ST_WRITE;
      ST_WRITE: nxt = seq_last ? ST_DONE : ST_READ;
      ST_DONE:  if (!go) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/sbist_obs.sv
module sbist_obs (
  input  logic clk,
  input  logic clr,
  input  logic start,
  input  logic chk_en,
  input  logic cap_en,
  input  logic msb,
  input  logic exp_msb,
  output logic fail,
  output logic sout
);
  always_ff @(posedge clk) begin
    if (clr) begin
      fail <= 1'b0;
      sout <= 1'b0;
    end else begin
      if (start)                         fail <= 1'b0;
      else if (chk_en && msb != exp_msb) fail <= 1'b1;
      if (cap_en) sout <= msb;
    end
  end
endmodule

// File: rtl/sbist_mux.sv
module sbist_mux #(
  parameter int AW = 3,
  parameter int DW = 4
) (
  input  logic          sel_test,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic          m_we,
  input  logic [AW-1:0] t_addr,
  input  logic [DW-1:0] t_wdata,
  input  logic          t_we,
  output logic [AW-1:0] o_addr,
  output logic [DW-1:0] o_wdata,
  output logic          o_we
);
  assign o_addr  = sel_test ? t_addr  : m_addr;
  assign o_wdata = sel_test ? t_wdata : m_wdata;
  assign o_we    = sel_test ? t_we    : m_we;
endmodule

// File: rtl/serial_ram_bist.sv
module serial_ram_bist
  import sbist_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int BITS  = 4,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bist_on,
  input  logic            go,
  output logic            done,
  output logic            fail,
  output logic            sout,
  input  logic [AW-1:0]   mis_addr,
  input  logic [BITS-1:0] mis_wdata,
  input  logic            mis_we,
  output logic [BITS-1:0] mis_rdata,
  output logic [AW-1:0]   ram_addr,
  output logic [BITS-1:0] ram_wdata,
  output logic            ram_we,
  input  logic [BITS-1:0] ram_rdata
);
  sbist_state_t    state;
  logic            clr, start, seq_last, in_write, ser_bit;
  logic [AW-1:0]   t_addr;
  logic [1:0]      grp;
  logic [BITS-1:0] t_wdata;

  assign clr       = rst || !bist_on;
  assign in_write  = (state == ST_WRITE);
  assign ser_bit   = (grp == 2'd1);
  assign t_wdata   = {ram_rdata[BITS-2:0], ser_bit};
  assign done      = (state == ST_DONE);
  assign mis_rdata = ram_rdata;

  sbist_ctrl u_ctrl (
    .clk(clk), .clr(clr), .go(go), .seq_last(seq_last),
    .state(state), .start(start)
  );

  sbist_seq #(.WORDS(WORDS), .BITS(BITS)) u_seq (
    .clk(clk), .clr(clr || start), .step(in_write),
    .addr(t_addr), .grp(grp), .last(seq_last)
  );

  sbist_obs u_obs (
    .clk(clk), .clr(clr), .start(start),
    .chk_en(in_write && grp != 2'd0), .cap_en(in_write),
    .msb(ram_rdata[BITS-1]), .exp_msb(grp == GRP_LAST),
    .fail(fail), .sout(sout)
  );

  sbist_mux #(.AW(AW), .DW(BITS)) u_mux (
    .sel_test(bist_on),
    .m_addr(mis_addr), .m_wdata(mis_wdata), .m_we(mis_we),
    .t_addr(t_addr), .t_wdata(t_wdata), .t_we(in_write),
    .o_addr(ram_addr), .o_wdata(ram_wdata), .o_we(ram_we)
  );
endmodule

// File: rtl/serial_ram_bist_chk.sv
module serial_ram_bist_chk #(
  parameter int AW   = 3,
  parameter int BITS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            bist_on,
  input logic            go,
  input logic            done,
  input logic            fail,
  input logic [AW-1:0]   mis_addr,
  input logic [BITS-1:0] mis_wdata,
  input logic            mis_we,
  input logic [AW-1:0]   ram_addr,
  input logic [BITS-1:0] ram_wdata,
  input logic            ram_we,
  input logic [BITS-1:0] ram_rdata
);
  AST_MISSION_PASS: assert property (@(posedge clk) disable iff (rst)
    !bist_on |-> (ram_addr == mis_addr && ram_wdata == mis_wdata && ram_we == mis_we)); // R1
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bist_on |=> (!done && !fail)); // R2
  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (bist_on && ram_we) |=> (!ram_we || !bist_on)); // R3
  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    (bist_on && ram_we && $past(bist_on) && !$past(rst)) |-> $stable(ram_addr)); // R3
  AST_WDATA_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (bist_on && ram_we) |-> (ram_wdata[BITS-1:1] == ram_rdata[BITS-2:0])); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && bist_on && !go) |=> (fail || !bist_on)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && go && bist_on) |=> done); // R7
endmodule

bind serial_ram_bist serial_ram_bist_chk #(.AW(AW), .BITS(BITS)) u_chk (
  .clk(clk), .rst(rst), .bist_on(bist_on), .go(go), .done(done), .fail(fail),
  .mis_addr(mis_addr), .mis_wdata(mis_wdata), .mis_we(mis_we),
  .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata)
);

// File: tb/sim_serial_ram_bist.sv
module sim_serial_ram_bist;
  localparam int W  = 8;
  localparam int B  = 4;
  localparam int AW = 3;
  localparam int RUN_CYC = 6 * B * W + 1;

  logic clk = 1'b0, rst = 1'b1, bist_on = 1'b0, go = 1'b0;
  logic done, fail, sout, ram_we, mis_we = 1'b0;
  logic [AW-1:0] mis_addr = '0, ram_addr;
  logic [B-1:0]  mis_wdata = '0, mis_rdata, ram_wdata, ram_rdata;

  int checks = 0, errors = 0;

  // RAM model, read-first, with one optional stuck cell on the read path
  logic [B-1:0] mem [W];
  logic         f_en = 1'b0, f_val = 1'b0;
  logic [AW-1:0] f_addr = '0;
  logic [1:0]   f_bit = '0;

  function automatic logic [B-1:0] faulted(input logic [B-1:0] v, input logic [AW-1:0] a);
    logic [B-1:0] r = v;
    if (f_en && a == f_addr) r[f_bit] = f_val;
    return r;
  endfunction

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= faulted(mem[ram_addr], ram_addr);
  end

  always #10 clk = ~clk;

  serial_ram_bist #(.WORDS(W), .BITS(B)) u0 (
    .clk(clk), .rst(rst), .bist_on(bist_on), .go(go), .done(done), .fail(fail),
    .sout(sout), .mis_addr(mis_addr), .mis_wdata(mis_wdata), .mis_we(mis_we),
    .mis_rdata(mis_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_rdata(ram_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {fault_en, addr[2:0], bit[1:0], stuck_val, expected fail}
  localparam logic [7:0] VEC [6] = '{
    {1'b0, 3'd0, 2'd0, 1'b0, 1'b0},
    {1'b1, 3'd3, 2'd3, 1'b0, 1'b1},
    {1'b1, 3'd0, 2'd0, 1'b1, 1'b1},
    {1'b1, 3'd7, 2'd1, 1'b0, 1'b1},
    {1'b1, 3'd5, 2'd2, 1'b1, 1'b1},
    {1'b0, 3'd0, 2'd0, 1'b0, 1'b0}
  };

  // runs one test with go held high; returns cycles to done and port mismatches
  task automatic run_bist(output int cyc, output int bad, output int nwr);
    cyc = 0; bad = 0; nwr = 0;
    go = 1'b1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (ram_we) begin
        if (ram_addr !== AW'(nwr % W)) bad++;
        if (ram_wdata !== {ram_rdata[B-2:0], ((nwr / (B * W)) == 1)}) bad++;
        nwr++;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc, bad, nwr;
    for (int i = 0; i < W; i++) mem[i] = B'(4'hF ^ i);
    repeat (3) @(negedge clk);
    check("R9 done after reset", done, 0);
    check("R9 fail after reset", fail, 0);
    check("R9 sout after reset", sout, 0);
    rst = 1'b0;

    // R1: mission pass-through
    @(negedge clk);
    mis_addr = 3'd5; mis_wdata = 4'h9; mis_we = 1'b1;
    #1;
    check("R1 addr pass", ram_addr, 5);
    check("R1 wdata pass", ram_wdata, 4'h9);
    check("R1 we pass", ram_we, 1);
    @(negedge clk);
    mis_we = 1'b0;
    @(negedge clk);
    check("R1 mission read back", mis_rdata, 4'h9);
    check("R1 rdata pass", mis_rdata, ram_rdata);

    // R2: go ignored while bist_on low
    go = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 done stays low", done, 0);
    check("R2 no test write", ram_we, 0);
    go = 1'b0;
    for (int i = 0; i < W; i++) mem[i] = B'(4'hF ^ i);
    bist_on = 1'b1;
    @(negedge clk);

    // table of fault vectors
    for (int v = 0; v < 6; v++) begin
      f_en = VEC[v][7]; f_addr = VEC[v][6:4]; f_bit = VEC[v][3:2]; f_val = VEC[v][1];
      run_bist(cyc, bad, nwr);
      check($sformatf("R7 cycles to done vec%0d", v), cyc, RUN_CYC);
      check($sformatf("R3 R4 R5 write stream vec%0d", v), bad, 0);
      check($sformatf("R5 write count vec%0d", v), nwr, 3 * B * W);
      check($sformatf("R6 fail vec%0d", v), fail, VEC[v][0]);
      if (!f_en) check($sformatf("R8 sout vec%0d", v), sout, 1);
      go = 1'b0;
      @(negedge clk);
      check("R7 done drops after go", done, 0);
      check("R7 fail kept after go drop", fail, VEC[v][0]);
    end

    // R7: done holds while go stays high
    f_en = 1'b1; f_addr = 3'd2; f_bit = 2'd0; f_val = 1'b1;
    run_bist(cyc, bad, nwr);
    repeat (6) @(negedge clk);
    check("R7 done held with go high", done, 1);
    check("R6 fail held at done", fail, 1);
    go = 1'b0;
    @(negedge clk);
    check("R7 done low after release", done, 0);

    // R2: dropping bist_on clears the flags
    bist_on = 1'b0;
    @(negedge clk);
    check("R2 fail cleared when off", fail, 0);

    // R9: reset in the middle of a test
    bist_on = 1'b1; f_en = 1'b0; go = 1'b1;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid-run reset done", done, 0);
    check("R9 mid-run reset sout", sout, 0);
    check("R9 mid-run reset no write", ram_we, 0);
    rst = 1'b0; go = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule